// File: doc/BRIEF.md
# Dual-Clock Gray-Pointer FIFO

This block moves a stream of data words from a producer running on one clock to a consumer running on an unrelated clock. Words are stored in a small two-port array. The write side owns a write pointer and the read side owns a read pointer, and each side keeps its own reset. Neither pointer is sent across the boundary as a plain binary count. Each one is first turned into a registered Gray code and then passed through a two-stage synchronizer in the other domain. Because only one bit changes per step, the receiving side sees either the old position or the new one, and never a position that the sender did not hold.

The write side computes `full` from its synchronized copy of the read pointer. The read side computes `empty` from its synchronized copy of the write pointer. A synchronized copy can lag the true pointer, so both flags err on the safe side: `full` can stay high slightly too long and `empty` can stay high slightly too long, but neither flag ever lets a word be lost or read twice. The read port is fall-through. While `empty` is low, `rd_data` already shows the oldest word, and a read strobe removes it.

Top module: `gray_fifo`

## Requirements
- R1: After its own reset, the write side reports `full` = 0 and the read side reports `empty` = 1. Each reset is active low.
- R2: Words leave in the order they were written. While `empty` = 0, `rd_data` shows the oldest stored word before the read strobe removes it.
- R3: After DEPTH accepted writes with no reads, `full` rises at the rising `wclk` edge of the DEPTH-th write. DEPTH is 2**ADDR_W and is 8 by default.
- R4: A write strobe while `full` = 1 is ignored. The write pointer stays unchanged and the word is not stored, so exactly DEPTH words come back out.
- R5: A read strobe while `empty` = 1 is ignored. The read pointer stays unchanged, and the next word written is the next word read.
- R6: After a write into an empty FIFO, `empty` falls within four rising `rclk` edges.
- R7: Each pointer moves by at most one Gray step per clock of its own domain, so at most one bit changes per edge. The next pointer is computed as b ^ (b >> 1) and registered before it crosses.
- R8: A write and a read may happen in the same period while both clocks run freely. A long stream keeps its order with no loss and no duplicates.
- R9: After a read frees a slot in a full FIFO, `full` falls within four rising `wclk` edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-domain clock |
| wrst_n | input | 1 | Write-domain reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Word to store |
| full | output | 1 | No free slot, write-domain view |
| rclk | input | 1 | Read-domain clock |
| rrst_n | input | 1 | Read-domain reset, active low |
| rd_en | input | 1 | Read strobe, removes the word at the head |
| rd_data | output | DATA_W | Oldest stored word (fall-through) |
| empty | output | 1 | Nothing to read, read-domain view |

## Verification
The bench fills the FIFO to exactly DEPTH words. A design with a wrong full comparison would either raise `full` one word early or accept a ninth word and overwrite the head. The bench then pushes an extra word against `full` and drains the FIFO. A design that moved its write pointer while full would hand back the rejected word or a stale slot. It also strobes reads against an empty FIFO. A read pointer that advanced there would make the next written word disappear behind a phantom entry. Finally, it runs both clocks at unrelated rates with simultaneous traffic and checks every word in sequence. Broken Gray encoding or a mismatched synchronizer would show up as skipped or repeated words.

// File: rtl/afifo_pkg.sv
package afifo_pkg;

  // Binary count to reflected Gray code.
  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // Gray pattern that the write pointer shows when it is exactly one lap ahead
  // of the given read pointer: the two upper bits flipped, the rest equal.
  function automatic logic [31:0] lap_ahead(input logic [31:0] g, input int w);
    logic [31:0] m;
    m = 32'b11 << (w - 2);
    return g ^ m;
  endfunction

endpackage

// File: rtl/afifo_sync.sv
module afifo_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/afifo_mem.sv
module afifo_mem #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/afifo_ptr.sv
module afifo_ptr
  import afifo_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter bit IS_WRITE = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic [ADDR_W:0] remote_gray,
  output logic            fire,
  output logic [ADDR_W:0] bin,
  output logic [ADDR_W:0] gray,
  output logic            flag
);
  localparam int PTR_W = ADDR_W + 1;

  logic [PTR_W-1:0] bin_nx;
  logic [PTR_W-1:0] gray_nx;
  logic             flag_nx;

  assign fire    = req && !flag;
  assign bin_nx  = bin + PTR_W'(fire);
  assign gray_nx = PTR_W'(to_gray(32'(bin_nx)));

  generate
    if (IS_WRITE) begin : g_full
      assign flag_nx = (gray_nx == PTR_W'(lap_ahead(32'(remote_gray), PTR_W)));
    end else begin : g_empty
      assign flag_nx = (gray_nx == remote_gray);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin  <= '0;
      gray <= '0;
      flag <= !IS_WRITE;
    end else begin
      bin  <= bin_nx;
      gray <= gray_nx;
      flag <= flag_nx;
    end
  end
endmodule

// File: rtl/gray_fifo.sv
module gray_fifo #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              wclk,
  input  logic              wrst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              full,
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty
);
  localparam int PTR_W = ADDR_W + 1;

  // Named internal events, also observed by the bound checker.
  logic             wr_fire, rd_fire;
  logic [PTR_W-1:0] wbin, wgray, rbin, rgray;
  logic [PTR_W-1:0] wgray_at_r, rgray_at_w;

  afifo_ptr #(.ADDR_W(ADDR_W), .IS_WRITE(1'b1)) u_wside (
    .clk(wclk), .rst_n(wrst_n), .req(wr_en), .remote_gray(rgray_at_w),
    .fire(wr_fire), .bin(wbin), .gray(wgray), .flag(full)
  );

  afifo_ptr #(.ADDR_W(ADDR_W), .IS_WRITE(1'b0)) u_rside (
    .clk(rclk), .rst_n(rrst_n), .req(rd_en), .remote_gray(wgray_at_r),
    .fire(rd_fire), .bin(rbin), .gray(rgray), .flag(empty)
  );

  afifo_sync #(.W(PTR_W)) u_w2r (
    .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_at_r)
  );

  afifo_sync #(.W(PTR_W)) u_r2w (
    .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_at_w)
  );

  afifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wclk(wclk), .we(wr_fire), .waddr(wbin[ADDR_W-1:0]), .wdata(wr_data),
    .raddr(rbin[ADDR_W-1:0]), .rdata(rd_data)
  );
endmodule

// File: rtl/gray_fifo_chk.sv
module gray_fifo_chk #(
  parameter int PTR_W = 4
) (
  input logic             wclk,
  input logic             wrst_n,
  input logic             wr_en,
  input logic             full,
  input logic [PTR_W-1:0] wgray,
  input logic             rclk,
  input logic             rrst_n,
  input logic             rd_en,
  input logic             empty,
  input logic [PTR_W-1:0] rgray
);
  // R4: a write strobe against full leaves the write pointer in place
  p_no_overflow_r4: assert property (@(posedge wclk) disable iff (!wrst_n)
    (wr_en && full) |=> $stable(wgray));

  // R5: a read strobe against empty leaves the read pointer in place
  p_no_underflow_r5: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rd_en && empty) |=> $stable(rgray));

  // R7: write-side Gray pointer changes at most one bit per edge
  p_wgray_step_r7: assert property (@(posedge wclk) disable iff (!wrst_n)
    $countones(wgray ^ $past(wgray)) <= 1);

  // R7: read-side Gray pointer changes at most one bit per edge
  p_rgray_step_r7: assert property (@(posedge rclk) disable iff (!rrst_n)
    $countones(rgray ^ $past(rgray)) <= 1);

  // R4: without a write strobe the write pointer holds
  p_wr_idle_r4: assert property (@(posedge wclk) disable iff (!wrst_n)
    !wr_en |=> $stable(wgray));
endmodule

bind gray_fifo gray_fifo_chk #(.PTR_W(PTR_W)) u_chk (
  .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .full(full), .wgray(wgray),
  .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en), .empty(empty), .rgray(rgray)
);

// File: tb/tb_gray_fifo.sv
module tb_gray_fifo;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int DEPTH  = 1 << ADDR_W;

  logic wclk = 0, rclk = 0;
  logic wrst_n = 0, rrst_n = 0;
  logic wr_en = 0, rd_en = 0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic full, empty;

  int checks = 0;
  int errors = 0;

  always #2 wclk = ~wclk;   // 250 MHz
  always #3 rclk = ~rclk;   // unrelated read clock

  gray_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (
    .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .wr_data(wr_data), .full(full),
    .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en), .rd_data(rd_data), .empty(empty)
  );

  localparam logic [DATA_W-1:0] VEC [DEPTH] =
    '{8'h11, 8'hA5, 8'h00, 8'hFF, 8'h3C, 8'h80, 8'h01, 8'h7E};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic push(input logic [DATA_W-1:0] d);
    @(negedge wclk); wr_en = 1; wr_data = d;
    @(negedge wclk); wr_en = 0;
  endtask

  task automatic pop_expect(input logic [DATA_W-1:0] exp, input string req);
    @(negedge rclk);
    check(!empty, req, empty, 0);
    check(rd_data == exp, req, rd_data, exp);
    rd_en = 1;
    @(negedge rclk); rd_en = 0;
  endtask

  task automatic settle();
    repeat (6) @(negedge rclk);
    repeat (6) @(negedge wclk);
  endtask

  initial begin
    repeat (200000) @(posedge wclk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    int n;
    // R1: reset state
    repeat (3) @(negedge wclk);
    check(empty == 1, "R1 empty in reset", empty, 1);
    check(full == 0, "R1 full in reset", full, 0);
    wrst_n = 1; rrst_n = 1;
    settle();
    check(empty == 1, "R1 empty after reset", empty, 1);
    check(full == 0, "R1 full after reset", full, 0);

    // R6: empty falls soon after a write
    push(8'h42);
    n = 0;
    for (int i = 0; i < 8; i++) begin
      if (!empty) break;
      @(negedge rclk); n++;
    end
    check(n <= 4, "R6 empty release latency", n, 4);
    pop_expect(8'h42, "R2 single word");
    @(negedge rclk);
    check(empty == 1, "R2 empty after draining", empty, 1);

    // R3/R2: table walk to full
    for (int i = 0; i < DEPTH; i++) begin
      push(VEC[i]);
      check(full == (i == DEPTH - 1), "R3 full at depth", full, (i == DEPTH - 1));
    end
    // R4: write against full is ignored
    push(8'hEE);
    check(full == 1, "R4 full held", full, 1);
    settle();
    pop_expect(VEC[0], "R2 order head");
    // R9: full falls after a read
    n = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge wclk);
      if (!full) break;
      n++;
    end
    check(n <= 4, "R9 full release latency", n, 4);
    for (int i = 1; i < DEPTH; i++) pop_expect(VEC[i], "R2 R4 order no overflow word");
    settle();
    check(empty == 1, "R4 rejected word not stored", empty, 1);

    // R5: reads against empty are ignored
    repeat (3) begin
      @(negedge rclk); rd_en = 1;
    end
    @(negedge rclk); rd_en = 0;
    push(8'h5A);
    settle();
    pop_expect(8'h5A, "R5 next word after empty reads");
    @(negedge rclk);
    check(empty == 1, "R5 empty after one read", empty, 1);

    // R8: concurrent streaming
    fork
      begin
        int k = 0;
        while (k < 40) begin
          @(negedge wclk);
          if (!full) begin wr_en = 1; wr_data = DATA_W'(k * 7 + 3); k++; end
          else wr_en = 0;
        end
        @(negedge wclk); wr_en = 0;
      end
      begin
        int k = 0;
        while (k < 40) begin
          @(negedge rclk);
          if (!empty) begin
            check(rd_data == DATA_W'(k * 7 + 3), "R8 stream order", rd_data, DATA_W'(k * 7 + 3));
            rd_en = 1; k++;
          end else rd_en = 0;
        end
        @(negedge rclk); rd_en = 0;
      end
    join
    settle();
    check(empty == 1, "R8 empty after stream", empty, 1);

    // R1: reset with data in flight
    push(8'h99); push(8'h98);
    settle();
    @(negedge wclk); wrst_n = 0; rrst_n = 0;
    @(negedge rclk);
    check(empty == 1, "R1 empty on mid-run reset", empty, 1);
    check(full == 0, "R1 full on mid-run reset", full, 0);
    summary();
  end
endmodule